// File: doc/BRIEF.md
# Multiply-Accumulate Processing Element

This block is one processing element of a matrix-multiply array. Each accepted operand beat brings a broadcast row operand and a weight operand. The element multiplies the two and adds the product to one of several partial sums that it keeps locally. An index on the beat picks the partial sum, so the element can build several output columns at once. The weight is also copied to a registered pass-through output, so the next element in the chain can use it one cycle later.

Two flags on each beat control the accumulation. A start flag makes the adder begin from zero instead of the stored partial sum. An end flag sends the finished sum out on the result stream instead of writing it back to the local store. A qualifier bit marks whether the operands are usable. A beat without it is still accepted and its weight is still forwarded, but it has no effect on any sum.

The operand input is a valid/ready stream, and so is the result output. A beat is taken on a rising edge when `op_valid` and `op_ready` are both high. A result leaves on a rising edge when `res_valid` and `res_ready` are both high. While a result waits with `res_ready` low, the whole element holds: `op_ready` drops, and the result data and index stay fixed. When no result is waiting, `op_ready` is high and the element takes one beat every clock.

Top module: `mac_pe`

## Requirements
- R1: After reset, `op_ready` is 1 and both `res_valid` and `w_out_valid` are 0.
- R2: When a beat with `op_ok`=1 and `op_last`=1 is accepted, `res_valid` rises two clock edges later, provided the result stream was not stalled. At that point `res_data` holds the two's-complement sum of `op_i*op_w` over the qualified beats of that index, counted from its most recent start beat up to and including this one. `res_idx` holds the index.
- R3: A qualified beat with `op_first`=1 adds its product to zero, not to the stored partial sum.
- R4: A beat with `op_ok`=0 changes no partial sum and produces no result, whatever its `op_first` and `op_last` flags say.
- R5: On the clock edge after a beat is accepted (qualified or not), `w_out` holds that beat's `op_w` and `w_out_valid` is 1. In any cycle that follows an edge with no accepted beat, `w_out_valid` is 0.
- R6: Back-to-back qualified beats to the same index give the correct running sum with no lost update.
- R7: Partial sums at different indices (0 to NACC-1) build up independently when their beats are interleaved.
- R8: Beats with `op_last`=0 never raise `res_valid`.
- R9: While `res_valid`=1 and `res_ready`=0, `op_ready` is 0, and `res_data` and `res_idx` stay stable until the result is taken. No beat and no result is lost.
- R10: While no result is held back (`res_valid`=0), `op_ready` is 1, so the element keeps up one beat per clock.
- R11: Operands are signed two's complement of width DW. The accumulator is signed, of width AW.
- R12: A qualified beat with both `op_first` and `op_last` set produces exactly `op_i*op_w`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operand beat offered |
| op_ready | output | 1 | Element can take a beat |
| op_i | input | DW | Broadcast row operand, signed |
| op_w | input | DW | Weight operand, signed |
| op_ok | input | 1 | Operands qualified; 0 makes the beat a no-op for the sums |
| op_idx | input | IDXW | Partial-sum index |
| op_first | input | 1 | Start a fresh sum from zero |
| op_last | input | 1 | Export the sum instead of storing it |
| w_out | output | DW | Weight forwarded to the next element |
| w_out_valid | output | 1 | `w_out` carries a newly accepted weight |
| res_valid | output | 1 | Finished sum offered |
| res_ready | input | 1 | Downstream takes the sum |
| res_data | output | AW | Finished sum, signed |
| res_idx | output | IDXW | Index of the finished sum |

## Verification
The bench builds the element with DW=8, AW=20 and NACC=4. The 8-bit operands let it drive the most negative value times itself and mixed-sign products, so the sign handling is tested at its edges. The 20-bit accumulator has room for the chosen sums, so any difference from the expected value comes from wrong behaviour, not from wrap-around. With four indices, the bench can interleave sums on the first and last index of the store, and it can send back-to-back beats to one index so that the read-after-write forwarding is tested. A pattern on `res_ready` that holds results back stalls the element in the middle of a run, which tests the hold behaviour and checks that no beat or result is lost.

// File: rtl/mac_pe_pkg.sv
package mac_pe_pkg;

  // Where a finished sum goes when it leaves the adder stage.
  typedef enum logic {
    DEST_STORE  = 1'b0,
    DEST_EXPORT = 1'b1
  } sum_dest_e;

  function automatic sum_dest_e pick_dest(input logic last_flag);
    return last_flag ? DEST_EXPORT : DEST_STORE;
  endfunction

endpackage

// File: rtl/pe_mul_stage.sv
module pe_mul_stage #(
  parameter int DW   = 16,
  parameter int IDXW = 2,
  localparam int PW  = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic                 fire,
  input  logic                 ok,
  input  logic signed [DW-1:0] row_op,
  input  logic signed [DW-1:0] wgt_op,
  input  logic [IDXW-1:0]      idx,
  input  logic                 first,
  input  logic                 last,
  output logic                 m_valid,
  output logic signed [PW-1:0] m_prod,
  output logic [IDXW-1:0]      m_idx,
  output logic                 m_first,
  output logic                 m_last,
  output logic signed [DW-1:0] fwd_w,
  output logic                 fwd_valid
);

  // Multiply register: only qualified beats become live stage entries.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_prod  <= '0;
      m_idx   <= '0;
      m_first <= 1'b0;
      m_last  <= 1'b0;
    end else if (advance) begin
      m_valid <= fire & ok;
      if (fire & ok) begin
        m_prod  <= row_op * wgt_op;
        m_idx   <= idx;
        m_first <= first;
        m_last  <= last;
      end
    end
  end

  // Weight pass-through: every accepted beat forwards its weight.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_w     <= '0;
      fwd_valid <= 1'b0;
    end else begin
      fwd_valid <= fire;
      if (fire) fwd_w <= wgt_op;
    end
  end

endmodule

// File: rtl/pe_acc_store.sv
module pe_acc_store #(
  parameter int AW   = 40,
  parameter int NACC = 4,
  parameter int IDXW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDXW-1:0]      rd_idx,
  output logic signed [AW-1:0] rd_data,
  input  logic                 wr_en,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic signed [AW-1:0] wr_data
);

  logic signed [AW-1:0] slots [NACC];

  generate
    for (genvar g = 0; g < NACC; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          slots[g] <= '0;
        else if (wr_en && (32'(wr_idx) == g))
          slots[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NACC; k++)
      if (32'(rd_idx) == k) rd_data = slots[k];
  end

endmodule

// File: rtl/pe_acc_stage.sv
module pe_acc_stage
  import mac_pe_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 40,
  parameter int IDXW = 2,
  localparam int PW  = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic                 m_valid,
  input  logic signed [PW-1:0] m_prod,
  input  logic [IDXW-1:0]      m_idx,
  input  logic                 m_first,
  input  logic                 m_last,
  output logic [IDXW-1:0]      rd_idx,
  input  logic signed [AW-1:0] rd_data,
  output logic                 wr_en,
  output logic [IDXW-1:0]      wr_idx,
  output logic signed [AW-1:0] wr_data,
  output logic                 s_valid,
  output logic                 s_export,
  output logic signed [AW-1:0] s_sum,
  output logic [IDXW-1:0]      s_idx
);

  sum_dest_e            s_dest;
  logic signed [AW-1:0] prod_ext;
  logic signed [AW-1:0] base;
  logic signed [AW-1:0] partial;
  logic                 fwd_hit;

  assign prod_ext = {{(AW-PW){m_prod[PW-1]}}, m_prod};
  assign rd_idx   = m_idx;

  // The entry in the sum register writes the store on the same edge that
  // this stage reads it, so a matching index takes the sum directly.
  assign fwd_hit  = s_valid && (s_dest == DEST_STORE) && (s_idx == m_idx);
  assign partial  = fwd_hit ? s_sum : rd_data;
  assign base     = m_first ? '0 : partial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_dest  <= DEST_STORE;
      s_sum   <= '0;
      s_idx   <= '0;
    end else if (advance) begin
      s_valid <= m_valid;
      if (m_valid) begin
        s_dest <= pick_dest(m_last);
        s_sum  <= base + prod_ext;
        s_idx  <= m_idx;
      end
    end
  end

  assign s_export = s_valid && (s_dest == DEST_EXPORT);
  assign wr_en    = s_valid && (s_dest == DEST_STORE);
  assign wr_idx   = s_idx;
  assign wr_data  = s_sum;

endmodule

// File: rtl/mac_pe.sv
module mac_pe #(
  parameter int DW   = 16,
  parameter int AW   = 40,
  parameter int NACC = 4,
  localparam int IDXW = (NACC > 1) ? $clog2(NACC) : 1,
  localparam int PW   = 2 * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [DW-1:0]   op_i,
  input  logic [DW-1:0]   op_w,
  input  logic            op_ok,
  input  logic [IDXW-1:0] op_idx,
  input  logic            op_first,
  input  logic            op_last,
  output logic [DW-1:0]   w_out,
  output logic            w_out_valid,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [AW-1:0]   res_data,
  output logic [IDXW-1:0] res_idx
);

  logic                 stall;
  logic                 advance;
  logic                 fire;
  logic                 m_valid;
  logic signed [PW-1:0] m_prod;
  logic [IDXW-1:0]      m_idx;
  logic                 m_first;
  logic                 m_last;
  logic signed [DW-1:0] fwd_w;
  logic [IDXW-1:0]      rd_idx;
  logic signed [AW-1:0] rd_data;
  logic                 wr_en;
  logic [IDXW-1:0]      wr_idx;
  logic signed [AW-1:0] wr_data;
  logic                 s_valid;
  logic                 s_export;
  logic signed [AW-1:0] s_sum;
  logic [IDXW-1:0]      s_idx;

  // Only an exported sum that is refused can block the pipe.
  assign stall    = s_export && !res_ready;
  assign advance  = !stall;
  assign op_ready = advance;
  assign fire     = op_valid && op_ready;

  pe_mul_stage #(.DW(DW), .IDXW(IDXW)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .fire      (fire),
    .ok        (op_ok),
    .row_op    (signed'(op_i)),
    .wgt_op    (signed'(op_w)),
    .idx       (op_idx),
    .first     (op_first),
    .last      (op_last),
    .m_valid   (m_valid),
    .m_prod    (m_prod),
    .m_idx     (m_idx),
    .m_first   (m_first),
    .m_last    (m_last),
    .fwd_w     (fwd_w),
    .fwd_valid (w_out_valid)
  );

  pe_acc_store #(.AW(AW), .NACC(NACC), .IDXW(IDXW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
  );

  pe_acc_stage #(.DW(DW), .AW(AW), .IDXW(IDXW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .m_valid  (m_valid),
    .m_prod   (m_prod),
    .m_idx    (m_idx),
    .m_first  (m_first),
    .m_last   (m_last),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .s_valid  (s_valid),
    .s_export (s_export),
    .s_sum    (s_sum),
    .s_idx    (s_idx)
  );

  assign w_out     = fwd_w;
  assign res_valid = s_export;
  assign res_data  = s_sum;
  assign res_idx   = s_idx;

endmodule

// File: rtl/mac_pe_chk.sv
module mac_pe_chk #(
  parameter int DW   = 16,
  parameter int AW   = 40,
  parameter int IDXW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            op_ready,
  input logic [DW-1:0]   op_w,
  input logic [DW-1:0]   w_out,
  input logic            w_out_valid,
  input logic            res_valid,
  input logic            res_ready,
  input logic [AW-1:0]   res_data,
  input logic [IDXW-1:0] res_idx
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_idx)));

  p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !op_ready);

  p_wfwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> (w_out_valid && (w_out == $past(op_w))));

  p_nofwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_ready) |=> !w_out_valid);

  p_rate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> op_ready);

endmodule

bind mac_pe mac_pe_chk #(.DW(DW), .AW(AW), .IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_ready    (op_ready),
  .op_w        (op_w),
  .w_out       (w_out),
  .w_out_valid (w_out_valid),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_data    (res_data),
  .res_idx     (res_idx)
);

// File: tb/sim_mac_pe.sv
`timescale 1ns/1ps
module sim_mac_pe;
  localparam int DW = 8;
  localparam int AW = 20;
  localparam int NACC = 4;
  localparam int IDXW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            op_valid = 1'b0;
  logic            op_ready;
  logic [DW-1:0]   op_i = '0;
  logic [DW-1:0]   op_w = '0;
  logic            op_ok = 1'b0;
  logic [IDXW-1:0] op_idx = '0;
  logic            op_first = 1'b0;
  logic            op_last = 1'b0;
  logic [DW-1:0]   w_out;
  logic            w_out_valid;
  logic            res_valid;
  logic            res_ready = 1'b1;
  logic [AW-1:0]   res_data;
  logic [IDXW-1:0] res_idx;

  int nchk = 0;
  int nfail = 0;
  bit bp_on = 1'b0;
  int cyc = 0;
  logic [IDXW+AW-1:0] expq [$];
  logic signed [AW-1:0] model [NACC];

  always #2 clk = ~clk;

  mac_pe #(.DW(DW), .AW(AW), .NACC(NACC)) u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  // Driver: called at a negedge, returns at the negedge after acceptance.
  task automatic send(input int iv, input int wv, input bit ok, input int idx,
                      input bit first, input bit last);
    logic signed [AW-1:0] p;
    op_valid = 1'b1; op_i = DW'(iv); op_w = DW'(wv); op_ok = ok;
    op_idx = IDXW'(idx); op_first = first; op_last = last;
    #1;
    if (!bp_on) chk(op_ready == 1'b1, "R10 op_ready", op_ready, 1);
    while (!op_ready) begin
      @(negedge clk); #1;
    end
    if (ok) begin
      p = AW'(iv * wv);
      model[idx] = first ? p : model[idx] + p;
      if (last) expq.push_back({IDXW'(idx), model[idx]});
    end
    @(posedge clk);
    @(negedge clk);
    chk(w_out_valid && (w_out == DW'(wv)), "R5 w_out", {w_out_valid, w_out}, {1'b1, DW'(wv)});
  endtask

  task automatic idle(input int n);
    op_valid = 1'b0; op_ok = 1'b0; op_first = 1'b0; op_last = 1'b0;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Monitor: compares exported sums with the scoreboard queue.
  initial begin
    bit held = 1'b0;
    logic [IDXW+AW-1:0] held_v;
    logic [IDXW+AW-1:0] e;
    forever begin
      @(negedge clk);
      cyc++;
      res_ready = bp_on ? ((cyc % 3) == 0) : 1'b1;
      #1;
      if (held) chk(res_valid && ({res_idx, res_data} == held_v), "R9 hold",
                    {res_idx, res_data}, held_v);
      held = 1'b0;
      if (res_valid && rst_n) begin
        if (!res_ready) begin
          held = 1'b1; held_v = {res_idx, res_data};
        end else if (expq.size() == 0) begin
          chk(1'b0, "R8 unexpected result", res_data, 0);
        end else begin
          e = expq.pop_front();
          chk({res_idx, res_data} == e, "R2 result", {res_idx, res_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < NACC; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(op_ready == 1'b1, "R1 op_ready", op_ready, 1);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(w_out_valid == 1'b0, "R1 w_out_valid", w_out_valid, 0);
    @(negedge clk);

    // R12: single beat
    send(3, 5, 1, 0, 1, 1);
    idle(3);
    chk(w_out_valid == 1'b0, "R5 idle", w_out_valid, 0);

    // R6: back-to-back updates to one index
    send(2, 3, 1, 1, 1, 0);
    send(4, 5, 1, 1, 0, 0);
    send(-6, 7, 1, 1, 0, 0);
    send(9, 1, 1, 1, 0, 1);

    // R3: a fresh start on the same index drops the old sum
    send(10, 10, 1, 1, 1, 0);
    send(1, 2, 1, 1, 0, 1);

    // R11: signed extremes
    send(-128, -128, 1, 2, 1, 0);
    send(-128, 127, 1, 2, 0, 0);
    send(7, -3, 1, 2, 0, 1);

    // R7: interleaved indices 0 and 3
    send(5, 5, 1, 0, 1, 0);
    send(-4, 6, 1, 3, 1, 0);
    send(3, 3, 1, 0, 0, 0);
    send(11, 2, 1, 3, 0, 0);
    send(1, 1, 1, 0, 0, 1);
    send(2, -9, 1, 3, 0, 1);

    // R4: unqualified beats with every flag combination, R8: no result from them
    send(6, 6, 1, 1, 1, 0);
    send(50, 50, 0, 1, 1, 0);
    send(50, 50, 0, 1, 0, 1);
    send(50, 50, 0, 1, 1, 1);
    idle(4);
    send(1, 1, 1, 1, 0, 1);
    idle(4);

    // R9: result back-pressure in the middle of a stream
    bp_on = 1'b1;
    for (int k = 0; k < 6; k++) begin
      send(k + 1, 3, 1, k % NACC, 1, 1);
      send(k, -2, 1, (k + 1) % NACC, 1, 0);
      send(k + 2, 2, 1, (k + 1) % NACC, 0, 1);
    end
    idle(2);
    bp_on = 1'b0;

    for (int k = 0; k < 200 && expq.size() != 0; k++) @(negedge clk);
    chk(expq.size() == 0, "R2 all results delivered", expq.size(), 0);
    summary();
    $finish;
  end

endmodule